// File: doc/BRIEF.md
# Nested priority interrupt controller

This block gathers interrupt requests from eight sources, such as program faults, a timer, I/O controllers and hardware error detectors. Each new request is held as pending. The block offers exactly one interrupt at a time to the processor, together with the handler start address read from a vector table indexed by the source number. The processor checks the request line once per instruction cycle. It takes the interrupt with an acknowledge and signals that the handler is done with an end-of-service strobe.

A mode input selects the service policy and may change at run time. In sequential mode, nothing new is offered while any handler is active. Requests keep waiting and are served one after another. In nested mode, a request whose priority is strictly above the running handler interrupts it. A stack of pre-empted levels makes each finished handler hand control back to the level it interrupted. Priority is fixed by source index, and a higher index is more urgent. A global enable and a per-source mask hold back presentation without discarding pending requests.

Top module: `prio_irq_nest`

## Requirements
- R1: After reset, `irq_o`, `src_o`, `vec_o`, `busy_o` and `lvl_o` are all zero, no source is pending and the level stack is empty.
- R2: A source becomes pending on a 0-to-1 change of its request line, as sampled on the clock. A line held high after being serviced does not make the source pending again.
- R3: The source offered is the highest-index pending source that is not masked. `irq_o` rises on the clock edge after the one that latched the request. An acknowledge while `irq_o` is high clears that source's pending bit, drops `irq_o` on the same edge and pushes the source number as the new active level.
- R4: From the cycle `irq_o` rises until it is acknowledged, `irq_o`, `src_o` and `vec_o` stay unchanged.
- R5: With `nest_i` low, no interrupt is offered while the level stack is non-empty.
- R6: With `nest_i` high and a handler active, a source is offered only if its index is strictly greater than the active level `lvl_o`. A request at an equal or lower level stays pending.
- R7: `eos_i` pops one level. `busy_o` and `lvl_o` then show the interrupted level, and waiting requests are judged against that level from the next cycle on.
- R8: A source whose `mask_i` bit is 1 is not offered, and nothing is offered while `en_i` is 0. Its pending bit is kept, so clearing the mask or setting the enable lets it be offered.
- R9: A write with `tab_we_i` high stores `tab_data_i` as the vector of source `tab_idx_i`. The vector output for that source then carries the stored value.
- R10: In nested mode, a level-2 handler that is pre-empted by source 5 runs as follows. A source-4 request raised during the source-5 handler is offered only after source 5 ends, and it runs before level 2 resumes.
- R11: `eos_i` with an empty stack, and `ack_i` while `irq_o` is low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request lines, one per source |
| nest_i | input | 1 | 1 = nested service, 0 = sequential service |
| en_i | input | 1 | Global interrupt enable |
| mask_i | input | 8 | Per-source mask, 1 blocks the source |
| tab_we_i | input | 1 | Vector table write strobe |
| tab_idx_i | input | 3 | Vector table entry to write |
| tab_data_i | input | 16 | Handler address to store |
| ack_i | input | 1 | Processor takes the offered interrupt |
| eos_i | input | 1 | End of the current handler |
| irq_o | output | 1 | Interrupt offered to the processor |
| src_o | output | 3 | Number of the offered source |
| vec_o | output | 16 | Handler address of the offered source |
| busy_o | output | 1 | At least one handler is active |
| lvl_o | output | 3 | Level of the innermost active handler |

## Verification
A bad pending bit or a misordered stack does not show up at once. It appears later, when a request is offered too early, too late or with the wrong number, often several handlers after the corruption. For that reason, a behavioural model tracks pending bits and the level stack independently, and the ports are compared with it every cycle. Directed runs of the pre-emption sequence and the two policies place each stack push and pop where one wrong entry would change `lvl_o` or `src_o` within a cycle or two.

// File: rtl/prio_irq_nest.sv
module prio_irq_nest #(
  parameter int NSRC  = 8,
  parameter int VW    = 16,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            nest_i,
  input  logic            en_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            tab_we_i,
  input  logic [IW-1:0]   tab_idx_i,
  input  logic [VW-1:0]   tab_data_i,
  input  logic            ack_i,
  input  logic            eos_i,
  output logic            irq_o,
  output logic [IW-1:0]   src_o,
  output logic [VW-1:0]   vec_o,
  output logic            busy_o,
  output logic [IW-1:0]   lvl_o
);
  localparam int DW  = $clog2(DEPTH);
  localparam int SPW = $clog2(DEPTH + 1);

  logic [NSRC-1:0] req_q, pend, elig, clr;
  logic [VW-1:0]   tab [NSRC];
  logic [IW-1:0]   stk [DEPTH];
  logic [SPW-1:0]  sp;
  logic [IW-1:0]   cand, top;
  logic [DW-1:0]   top_idx, wr_idx;
  logic            any, pres, take, pop;

  assign elig    = pend & ~mask_i & {NSRC{en_i}};
  assign any     = |elig;
  assign busy_o  = sp != '0;
  assign top_idx = DW'(sp - 1'b1);
  assign top     = stk[top_idx];
  assign lvl_o   = busy_o ? top : '0;
  assign take    = irq_o & ack_i;
  assign pop     = eos_i & busy_o;
  assign wr_idx  = DW'(sp - SPW'(pop));
  assign clr     = take ? (NSRC'(1) << src_o) : '0;
  assign pres    = any && (sp != SPW'(DEPTH)) && (!busy_o || (nest_i && cand > top));

  always_comb begin
    cand = '0;
    for (int i = 0; i < NSRC; i++)
      if (elig[i]) cand = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req_i;
      pend  <= (pend & ~clr) | (req_i & ~req_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) tab[i] <= '0;
    end else if (tab_we_i) begin
      tab[tab_idx_i] <= tab_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      sp <= sp - SPW'(pop) + SPW'(take);
      if (take) stk[wr_idx] <= src_o;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      src_o <= '0;
      vec_o <= '0;
    end else if (take) begin
      irq_o <= 1'b0;
    end else if (!irq_o && pres) begin
      irq_o <= 1'b1;
      src_o <= cand;
      vec_o <= tab[cand];
    end
  end
endmodule

// File: rtl/prio_irq_nest_chk.sv
module prio_irq_nest_chk #(
  parameter int NSRC = 8,
  parameter int VW   = 16,
  parameter int IW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            nest_i,
  input logic            en_i,
  input logic [NSRC-1:0] mask_i,
  input logic            ack_i,
  input logic            eos_i,
  input logic            irq_o,
  input logic [IW-1:0]   src_o,
  input logic [VW-1:0]   vec_o,
  input logic            busy_o,
  input logic [IW-1:0]   lvl_o
);
  logic [NSRC-1:0] mask_q;
  logic            en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      mask_q <= mask_i;
      en_q   <= en_i;
    end
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !ack_i |=> irq_o && $stable(src_o) && $stable(vec_o));

  p_seq_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o && !nest_i && busy_o && !eos_i |=> !irq_o);

  p_nest_higher_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) && $past(busy_o) && !$past(eos_i) |-> src_o > $past(lvl_o));

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> en_q && !mask_q[src_o]);

  p_ack_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && ack_i |=> !irq_o && busy_o && lvl_o == $past(src_o));

  p_idle_eos_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !(irq_o && ack_i) |=> !busy_o);
endmodule

bind prio_irq_nest prio_irq_nest_chk #(.NSRC(NSRC), .VW(VW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nest_i(nest_i), .en_i(en_i), .mask_i(mask_i),
  .ack_i(ack_i), .eos_i(eos_i), .irq_o(irq_o), .src_o(src_o), .vec_o(vec_o),
  .busy_o(busy_o), .lvl_o(lvl_o)
);

// File: tb/sim_prio_irq_nest.sv
module sim_prio_irq_nest;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  req = '0, mask = '0;
  logic        nest = 1'b0, en = 1'b1, we = 1'b0, ack = 1'b0, eos = 1'b0;
  logic [2:0]  widx = '0;
  logic [15:0] wdat = '0;
  logic        irq, busy;
  logic [2:0]  src, lvl;
  logic [15:0] vec;

  prio_irq_nest u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .nest_i(nest), .en_i(en), .mask_i(mask),
    .tab_we_i(we), .tab_idx_i(widx), .tab_data_i(wdat), .ack_i(ack), .eos_i(eos),
    .irq_o(irq), .src_o(src), .vec_o(vec), .busy_o(busy), .lvl_o(lvl)
  );

  int nchk = 0, nbad = 0;
  string tag = "R1";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  bit [7:0]    m_pend, m_rq;
  int          stk[$];
  bit          m_irq;
  int          m_src;
  logic [15:0] m_vec;
  logic [15:0] m_tab [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_rq = '0; stk.delete(); m_irq = 0; m_src = 0; m_vec = '0;
      for (int i = 0; i < 8; i++) m_tab[i] = '0;
    end else begin
      bit [7:0] el;
      int cd;
      bit pr, tk;
      el = m_pend & ~mask & {8{en}};
      cd = -1;
      for (int i = 0; i < 8; i++) if (el[i]) cd = i;
      pr = (cd >= 0) && stk.size() < 8 && (stk.size() == 0 || (nest && cd > stk[$]));
      tk = m_irq && ack;
      if (eos && stk.size() > 0) void'(stk.pop_back());
      if (tk) begin
        stk.push_back(m_src);
        m_pend[m_src] = 1'b0;
        m_irq = 0;
      end else if (!m_irq && pr) begin
        m_irq = 1; m_src = cd; m_vec = m_tab[cd];
      end
      m_pend = m_pend | (req & ~m_rq);
      m_rq = req;
      if (we) m_tab[widx] = wdat;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("model irq", irq, m_irq);
      chk("model src", src, m_src);
      chk("model vec", vec, m_vec);
      chk("model busy", busy, stk.size() > 0);
      chk("model lvl", lvl, stk.size() > 0 ? stk[$] : 0);
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse(int i); req[i] = 1'b1; cyc(1); req[i] = 1'b0; endtask
  task automatic ackit; ack = 1'b1; cyc(1); ack = 1'b0; endtask
  task automatic eosit; eos = 1'b1; cyc(1); eos = 1'b0; endtask
  task automatic wait_irq;
    int k = 0;
    while (!irq && k < 50) begin cyc(1); k++; end
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    cyc(2);
    tag = "R1";
    chk("reset irq", irq, 0); chk("reset src", src, 0); chk("reset vec", vec, 0);
    chk("reset busy", busy, 0); chk("reset lvl", lvl, 0);
    rst_n = 1'b1;
    cyc(2);
    chk("idle irq", irq, 0);

    tag = "R9";
    for (int i = 0; i < 8; i++) begin
      we = 1'b1; widx = 3'(i); wdat = 16'hA000 + 16'(i) * 16'h0111; cyc(1);
    end
    we = 1'b0;

    tag = "R3";
    req[3] = 1'b1; req[6] = 1'b1; cyc(1); req = '0; cyc(1);
    chk("irq up", irq, 1); chk("highest src", src, 6);
    chk("R9 vector", vec, 16'hA666);
    tag = "R4";
    cyc(5);
    chk("held irq", irq, 1); chk("held src", src, 6); chk("held vec", vec, 16'hA666);
    tag = "R3";
    ackit;
    chk("ack drops irq", irq, 0); chk("pushed busy", busy, 1); chk("pushed lvl", lvl, 6);

    tag = "R5";
    pulse(7); cyc(4);
    chk("seq blocked", irq, 0);
    eosit; cyc(1);
    chk("after eos irq", irq, 1); chk("after eos src", src, 7);
    ackit; eosit; cyc(1);
    chk("next waiting src", src, 3); chk("next waiting irq", irq, 1);
    ackit; eosit; cyc(2);
    chk("drained busy", busy, 0); chk("drained irq", irq, 0);

    tag = "R2";
    req[1] = 1'b1; wait_irq;
    chk("level src", src, 1);
    ackit; eosit; cyc(4);
    chk("held level no repeat", irq, 0);
    req[1] = 1'b0; cyc(1);

    tag = "R10";
    nest = 1'b1;
    pulse(2); wait_irq; chk("first src", src, 2); ackit;
    tag = "R6";
    pulse(5); wait_irq; chk("preempt src", src, 5); ackit;
    chk("preempt lvl", lvl, 5);
    pulse(4); cyc(4);
    chk("lower waits", irq, 0);
    tag = "R7";
    eosit; cyc(1);
    chk("R10 src4 after 5", src, 4); chk("R10 irq", irq, 1);
    ackit; chk("lvl 4", lvl, 4);
    eosit; chk("resume lvl 2", lvl, 2); chk("resume busy", busy, 1); chk("resume irq", irq, 0);
    eosit; chk("stack empty", busy, 0);

    tag = "R6";
    pulse(2); wait_irq; ackit;
    pulse(2); cyc(4);
    chk("equal waits", irq, 0);
    eosit; cyc(1);
    chk("equal later", irq, 1); chk("equal later src", src, 2);
    ackit; eosit; cyc(1);

    tag = "R8";
    mask[5] = 1'b1; pulse(5); cyc(4);
    chk("masked", irq, 0);
    mask = '0; cyc(1);
    chk("unmasked irq", irq, 1); chk("unmasked src", src, 5);
    ackit; eosit;
    en = 1'b0; pulse(3); cyc(3);
    chk("disabled", irq, 0);
    en = 1'b1; cyc(1);
    chk("enabled irq", irq, 1); chk("enabled src", src, 3);
    ackit; eosit; cyc(1);

    tag = "R11";
    chk("idle busy", busy, 0);
    eosit; chk("eos empty busy", busy, 0); chk("eos empty lvl", lvl, 0);
    ackit; cyc(1);
    chk("stray ack irq", irq, 0); chk("stray ack busy", busy, 0);

    tag = "R3 stress";
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) nest = ~nest;
      if (n % 37 == 0) mask = 8'($urandom) & 8'($urandom);
      if (n % 211 == 0) en = ($urandom % 4) != 0;
      req = 8'($urandom) & 8'($urandom) & 8'($urandom);
      ack = ($urandom % 3) == 0;
      eos = ($urandom % 5) == 0;
      cyc(1);
    end
    req = '0; mask = '0; en = 1'b1;
    for (int n = 0; n < 60; n++) begin
      ack = 1'b1; eos = n[0]; cyc(1);
    end
    ack = 1'b0; eos = 1'b0; cyc(2);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule